// File: doc/BRIEF.md
# Multi-CPU Auto-Masking Interrupt Controller

This block collects level-sensitive hardware interrupt lines from the rest of the chip and delivers them to a small cluster of CPUs. Each source has one mask bit and one software-trigger bit. A source's effective request is its hardware line ORed with its software bit. A routing field for each source chooses which CPUs can see it. Each CPU also owns two inter-processor interrupts (IPIs), which any CPU raises by register write. The two IPIs behave the same way, and only their priority order differs.

Every CPU services interrupts through one event register. Reading it returns the most urgent item pending for that CPU and acknowledges that item in the same access. If the item is a hardware source, its mask bit is set. If the item is an IPI, the IPI is cleared. Software later unmasks the hardware source with a write-one-to-clear access, so no read-modify-write is needed. Register accesses carry the ID of the issuing CPU. The register space has a default window that resolves to the issuing CPU, plus one explicit window for each CPU.

The word address is split into a view field in bits [11:8] and a register offset in bits [7:0]. The default configuration has two CPUs and 32 sources, and the source count may be at most 32.

Top module: `irq_hub`

## Requirements
- R1: After reset, every source is masked (mask word reads all ones), no software trigger or IPI is set, every source routes to all CPUs, `irq_out` is low, and an event read returns 0.
- R2: A hardware source is pending only while its line is high. Lowering the line withdraws the request, and nothing is latched.
- R3: The effective request of a source is its hardware line ORed with its software-trigger bit. Writing ones at offset 0x12 sets trigger bits and writing ones at offset 0x13 clears them. Offset 0x15 reads the trigger bits and offset 0x16 reads the raw hardware lines.
- R4: Writing ones at offset 0x10 sets mask bits and writing ones at offset 0x11 clears them. Zero bits leave the mask unchanged. Offset 0x14 reads the mask word.
- R5: The word at offset 0x40+n holds the routing of source n, with bit c enabling CPU c. A source is pending at CPU c only when it is unmasked, requested and routed to c.
- R6: The event register at offset 0x00 reads as {type in [17:16], number in [15:0]}. Type 0 means nothing is pending, type 1 means a hardware source and type 2 means an IPI. Among pending hardware sources, the lowest-numbered one is returned.
- R7: An event read that returns hardware source n sets mask bit n.
- R8: A write at offset 0x01 raises the IPIs selected by wdata[1:0] on the CPU named in wdata[15:8]. A target outside the CPU range is ignored. IPIs outrank hardware sources, and IPI 0 outranks IPI 1. An event read that returns an IPI clears it. Offset 0x02 reads the viewed CPU's IPI bits.
- R9: `irq_out[c]` is registered. It is high in the cycle after CPU c had any pending IPI or routed, unmasked, requested source, and it is low otherwise.
- R10: View 0 addresses the issuing CPU's registers and view k addresses CPU k-1. A view above the CPU count ignores writes, does not acknowledge, and reads return 0.
- R11: Every read produces `rsp_valid` with its data in the next cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | NSRC | Level-sensitive hardware interrupt lines |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address: view field and register offset |
| req_wdata | input | 32 | Write data |
| req_cpu | input | CPU_W | ID of the CPU making the access |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NCPU | Registered interrupt request for each CPU |

## Verification
Sources are raised both one at a time and several at once, including hardware and software triggers for the same number. This shows whether the encoder picks the lowest index or simply the most recent request. Acknowledging repeatedly and then unmasking shows that auto-masking hides only the delivered source and does not hide its neighbours. IPIs are mixed with pending hardware sources, and with each other, to confirm the fixed priority order. Routing one source to a single CPU, and reading through the default, explicit and out-of-range views, shows that each acknowledge reaches only the intended CPU.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HW   = 2'd1,
    EV_IPI  = 2'd2
  } ev_kind_e;

  localparam logic [7:0] OFS_EVENT    = 8'h00;
  localparam logic [7:0] OFS_IPI_SEND = 8'h01;
  localparam logic [7:0] OFS_IPI_PEND = 8'h02;
  localparam logic [7:0] OFS_MASK_SET = 8'h10;
  localparam logic [7:0] OFS_MASK_CLR = 8'h11;
  localparam logic [7:0] OFS_SWT_SET  = 8'h12;
  localparam logic [7:0] OFS_SWT_CLR  = 8'h13;
  localparam logic [7:0] OFS_MASK     = 8'h14;
  localparam logic [7:0] OFS_SWT      = 8'h15;
  localparam logic [7:0] OFS_HWLINE   = 8'h16;
  localparam logic [7:0] OFS_AFF_BASE = 8'h40;

  // index of the lowest set bit; 0 when none is set
  function automatic logic [15:0] lowest_set(input logic [31:0] v);
    logic [15:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 16'(i);
    end
    return r;
  endfunction

  function automatic logic [31:0] pack_event(input ev_kind_e k, input logic [15:0] n);
    return {14'd0, k, n};
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_hub_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NCPU  = 2,
  parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            hw_line,
  input  logic [NSRC-1:0]            mask_set,
  input  logic [NSRC-1:0]            mask_clr,
  input  logic [NSRC-1:0]            sw_set,
  input  logic [NSRC-1:0]            sw_clr,
  input  logic                       aff_we,
  input  logic [IDX_W-1:0]           aff_idx,
  input  logic [NCPU-1:0]            aff_wdata,
  output logic [NSRC-1:0]            mask_q,
  output logic [NSRC-1:0]            sw_q,
  output logic [NSRC-1:0][NCPU-1:0]  aff_q,
  output logic [NCPU-1:0][NSRC-1:0]  route_pend
);

  logic [NSRC-1:0] eff_req;
  assign eff_req = hw_line | sw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      sw_q   <= '0;
      aff_q  <= '1;
    end else begin
      mask_q <= (mask_q & ~mask_clr) | mask_set;
      sw_q   <= (sw_q & ~sw_clr) | sw_set;
      if (aff_we) aff_q[aff_idx] <= aff_wdata;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign route_pend[c][i] = eff_req[i] & ~mask_q[i] & aff_q[i][c];
    end
  end

  a_r4_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_clr & ~mask_set) != '0) |=> ((mask_q & $past(mask_clr & ~mask_set)) == '0));
  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set != '0) |=> ((mask_q & $past(mask_set)) == $past(mask_set)));
  a_r3_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set != '0) |=> ((sw_q & $past(sw_set)) == $past(sw_set)));

endmodule

// File: rtl/irq_ipi_bank.sv
module irq_ipi_bank #(
  parameter int NCPU = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCPU-1:0][1:0]  ipi_set,
  input  logic [NCPU-1:0][1:0]  ipi_clr,
  output logic [NCPU-1:0][1:0]  ipi_q
);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rst_n) ipi_q[c] <= 2'b00;
      else        ipi_q[c] <= (ipi_q[c] & ~ipi_clr[c]) | ipi_set[c];
    end
  end

  a_r8_ipi_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_set != '0) |=> ((ipi_q & $past(ipi_set)) == $past(ipi_set)));

endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pend,
  input  logic [1:0]      ipi_pend,
  output ev_kind_e        ev_kind,
  output logic [15:0]     ev_num,
  output logic [31:0]     ev_word,
  output logic            irq_o
);

  logic any_pend;
  assign any_pend = (|src_pend) | (|ipi_pend);

  always_comb begin
    ev_kind = EV_NONE;
    ev_num  = '0;
    if (ipi_pend[0]) begin
      ev_kind = EV_IPI;
      ev_num  = 16'd0;
    end else if (ipi_pend[1]) begin
      ev_kind = EV_IPI;
      ev_num  = 16'd1;
    end else if (|src_pend) begin
      ev_kind = EV_HW;
      ev_num  = lowest_set(32'(src_pend));
    end
  end

  assign ev_word = pack_event(ev_kind, ev_num);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_pend;
  end

  a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> irq_o);
  a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !irq_o);
  a_r8_ipi_outranks_hw: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == EV_HW) |-> (ipi_pend == 2'b00));
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == EV_HW) |-> (src_pend[ev_num] &&
      ((src_pend & ((NSRC'(1) << ev_num) - NSRC'(1))) == '0)));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NCPU  = 2,
  parameter int NSRC  = 32,
  parameter int AW    = 12,
  parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   hw_irq,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [NCPU-1:0]   irq_out
);

  localparam int VIEW_W = AW - 8;
  localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;

  // ---------------- decode ----------------
  logic [7:0]        ofs;
  logic [VIEW_W-1:0] view;
  logic [CPU_W-1:0]  tgt;
  logic              view_ok, rd_acc, wr_acc;

  assign ofs  = req_addr[7:0];
  assign view = req_addr[AW-1:8];

  always_comb begin
    if (view == '0) begin
      tgt     = req_cpu;
      view_ok = (int'(req_cpu) < NCPU);
    end else begin
      tgt     = CPU_W'(view - VIEW_W'(1));
      view_ok = (int'(view) <= NCPU);
    end
  end

  assign rd_acc = req_valid & ~req_write & view_ok;
  assign wr_acc = req_valid &  req_write & view_ok;

  logic [7:0] aff_off;
  logic       aff_hit;
  assign aff_off = ofs - OFS_AFF_BASE;
  assign aff_hit = (ofs >= OFS_AFF_BASE) && (int'(aff_off) < NSRC);

  // ---------------- per-CPU event selection ----------------
  logic [NSRC-1:0]            mask_q, sw_q;
  logic [NSRC-1:0][NCPU-1:0]  aff_q;
  logic [NCPU-1:0][NSRC-1:0]  route_pend;
  logic [NCPU-1:0][1:0]       ipi_q;
  ev_kind_e                   ev_kind_a [NCPU];
  logic [15:0]                ev_num_a  [NCPU];
  logic [31:0]                ev_word_a [NCPU];

  ev_kind_e    sel_kind;
  logic [15:0] sel_num;
  logic [31:0] sel_word;
  logic [1:0]  sel_ipi;

  always_comb begin
    sel_kind = EV_NONE;
    sel_num  = '0;
    sel_word = '0;
    sel_ipi  = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (tgt == CPU_W'(c)) begin
        sel_kind = ev_kind_a[c];
        sel_num  = ev_num_a[c];
        sel_word = ev_word_a[c];
        sel_ipi  = ipi_q[c];
      end
    end
  end

  // ---------------- internal events (named for checks) ----------------
  logic                  ack_fire;
  logic [NSRC-1:0]       ack_src_onehot;
  logic [NCPU-1:0][1:0]  ipi_clr_w, ipi_set_w;
  logic [NSRC-1:0]       mask_set_w, mask_clr_w, sw_set_w, sw_clr_w;
  logic                  aff_we;

  assign ack_fire       = rd_acc && (ofs == OFS_EVENT);
  assign ack_src_onehot = (ack_fire && sel_kind == EV_HW) ? (NSRC'(1) << sel_num) : '0;

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      for (int k = 0; k < 2; k++) begin
        ipi_clr_w[c][k] = ack_fire && (tgt == CPU_W'(c)) &&
                          (sel_kind == EV_IPI) && (sel_num == 16'(k));
        ipi_set_w[c][k] = wr_acc && (ofs == OFS_IPI_SEND) &&
                          (req_wdata[15:8] == 8'(c)) && req_wdata[k];
      end
    end
  end

  assign mask_set_w = ((wr_acc && ofs == OFS_MASK_SET) ? req_wdata[NSRC-1:0] : '0) | ack_src_onehot;
  assign mask_clr_w =  (wr_acc && ofs == OFS_MASK_CLR) ? req_wdata[NSRC-1:0] : '0;
  assign sw_set_w   =  (wr_acc && ofs == OFS_SWT_SET)  ? req_wdata[NSRC-1:0] : '0;
  assign sw_clr_w   =  (wr_acc && ofs == OFS_SWT_CLR)  ? req_wdata[NSRC-1:0] : '0;
  assign aff_we     = wr_acc && aff_hit;

  // ---------------- sub-blocks ----------------
  irq_src_bank #(.NSRC(NSRC), .NCPU(NCPU), .IDX_W(IDX_W)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_line    (hw_irq),
    .mask_set   (mask_set_w),
    .mask_clr   (mask_clr_w),
    .sw_set     (sw_set_w),
    .sw_clr     (sw_clr_w),
    .aff_we     (aff_we),
    .aff_idx    (aff_off[IDX_W-1:0]),
    .aff_wdata  (req_wdata[NCPU-1:0]),
    .mask_q     (mask_q),
    .sw_q       (sw_q),
    .aff_q      (aff_q),
    .route_pend (route_pend)
  );

  irq_ipi_bank #(.NCPU(NCPU)) u_ipi (
    .clk     (clk),
    .rst_n   (rst_n),
    .ipi_set (ipi_set_w),
    .ipi_clr (ipi_clr_w),
    .ipi_q   (ipi_q)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_port
    irq_cpu_port #(.NSRC(NSRC)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_pend (route_pend[c]),
      .ipi_pend (ipi_q[c]),
      .ev_kind  (ev_kind_a[c]),
      .ev_num   (ev_num_a[c]),
      .ev_word  (ev_word_a[c]),
      .irq_o    (irq_out[c])
    );
  end

  // ---------------- read path ----------------
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_EVENT:    rd_mux = sel_word;
      OFS_IPI_PEND: rd_mux = {30'd0, sel_ipi};
      OFS_MASK:     rd_mux = 32'(mask_q);
      OFS_SWT:      rd_mux = 32'(sw_q);
      OFS_HWLINE:   rd_mux = 32'(hw_irq);
      default: begin
        if (aff_hit) rd_mux = 32'(aff_q[aff_off[IDX_W-1:0]]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_rdata <= rd_acc ? rd_mux : '0;
    end
  end

  // ---------------- assertions ----------------
  a_r7_auto_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_src_onehot != '0) |=> ((mask_q & $past(ack_src_onehot)) == $past(ack_src_onehot)));
  a_r8_ipi_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_clr_w != '0) |=> ((ipi_q & $past(ipi_clr_w)) == '0));
  a_r11_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r11_no_write_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  a_r10_bad_view_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !view_ok) |=> ($stable(mask_q) && $stable(sw_q) && $stable(ipi_q)));
  a_r10_bad_view_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !view_ok) |=> (rsp_rdata == '0));

endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;

  localparam int NCPU = 2;
  localparam int NSRC = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   hw_irq = '0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [11:0]       req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [0:0]        req_cpu = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [NCPU-1:0]   irq_out;

  irq_hub #(.NCPU(NCPU), .NSRC(NSRC), .AW(12), .CPU_W(1)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  bit m_mask [NSRC];
  bit m_sw   [NSRC];
  bit m_aff  [NSRC][NCPU];
  bit m_ipi  [NCPU][2];

  function automatic void model_reset();
    for (int i = 0; i < NSRC; i++) begin
      m_mask[i] = 1; m_sw[i] = 0;
      for (int c = 0; c < NCPU; c++) m_aff[i][c] = 1;
    end
    for (int c = 0; c < NCPU; c++) begin m_ipi[c][0] = 0; m_ipi[c][1] = 0; end
  endfunction

  function automatic bit pend(int i, int c);
    return (hw_irq[i] | m_sw[i]) & !m_mask[i] & m_aff[i][c];
  endfunction

  function automatic logic [31:0] model_event(int c);
    if (m_ipi[c][0]) return 32'h0002_0000;
    if (m_ipi[c][1]) return 32'h0002_0001;
    for (int i = 0; i < NSRC; i++) if (pend(i, c)) return 32'h0001_0000 + i;
    return 32'h0;
  endfunction

  function automatic logic [NCPU-1:0] model_irq();
    logic [NCPU-1:0] r;
    r = '0;
    for (int c = 0; c < NCPU; c++) r[c] = (model_event(c) != 0);
    return r;
  endfunction

  function automatic logic [31:0] model_read(int c, int o);
    logic [31:0] r;
    r = 0;
    if (o == 'h00) r = model_event(c);
    else if (o == 'h02) r = {30'd0, m_ipi[c][1], m_ipi[c][0]};
    else if (o == 'h14) for (int i = 0; i < NSRC; i++) r[i] = m_mask[i];
    else if (o == 'h15) for (int i = 0; i < NSRC; i++) r[i] = m_sw[i];
    else if (o == 'h16) r = hw_irq;
    else if (o >= 'h40 && o < 'h40 + NSRC)
      for (int c2 = 0; c2 < NCPU; c2++) r[c2] = m_aff[o - 'h40][c2];
    return r;
  endfunction

  function automatic void model_ack(int c);
    logic [31:0] ev;
    ev = model_event(c);
    if (ev[17:16] == 2'd1) m_mask[ev[15:0]] = 1;
    else if (ev[17:16] == 2'd2) m_ipi[c][ev[0]] = 0;
  endfunction

  function automatic void model_write(int o, logic [31:0] wd);
    for (int i = 0; i < NSRC; i++) begin
      if (o == 'h10 && wd[i]) m_mask[i] = 1;
      if (o == 'h11 && wd[i]) m_mask[i] = 0;
      if (o == 'h12 && wd[i]) m_sw[i] = 1;
      if (o == 'h13 && wd[i]) m_sw[i] = 0;
    end
    if (o == 'h01 && int'(wd[15:8]) < NCPU) begin
      if (wd[0]) m_ipi[wd[15:8]][0] = 1;
      if (wd[1]) m_ipi[wd[15:8]][1] = 1;
    end
    if (o >= 'h40 && o < 'h40 + NSRC)
      for (int c = 0; c < NCPU; c++) m_aff[o - 'h40][c] = wd[c];
  endfunction

  // ---------------- one bus cycle, compared against the model ----------------
  task automatic step(input bit v, input bit wr, input int addr, input logic [31:0] wd,
                      input int cpu, input string req);
    logic [NCPU-1:0] exp_irq;
    logic [31:0] exp_rd;
    int c, vw, o;
    bit ok;
    req_valid = v; req_write = wr; req_addr = addr[11:0]; req_wdata = wd; req_cpu = cpu[0:0];
    exp_irq = model_irq();
    vw = addr >> 8; o = addr & 255;
    if (vw == 0) begin c = cpu; ok = 1; end
    else begin c = vw - 1; ok = (vw <= NCPU); end
    exp_rd = 0;
    if (v && !wr && ok) begin
      exp_rd = model_read(c, o);
      if (o == 0) model_ack(c);
    end
    if (v && wr && ok) model_write(o, wd);
    @(posedge clk); #2;
    checks++;
    if (irq_out !== exp_irq) begin
      errors++;
      $display("FAIL R9: irq_out=%b expected %b", irq_out, exp_irq);
    end
    checks++;
    if (rsp_valid !== (v && !wr)) begin
      errors++;
      $display("FAIL R11: rsp_valid=%b expected %b", rsp_valid, (v && !wr));
    end
    if (v && !wr) begin
      checks++;
      if (rsp_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s: addr=%h rdata=%h expected %h", req, addr, rsp_rdata, exp_rd);
      end
    end
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int addr, input int cpu, input string req);
    step(1, 0, addr, 0, cpu, req);
  endtask
  task automatic wr(input int addr, input logic [31:0] wd, input string req);
    step(1, 1, addr, wd, 0, req);
  endtask
  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset state
    idle("R1");
    rd('h000, 0, "R1");
    rd('h014, 0, "R1");
    rd('h015, 1, "R1");
    rd('h049, 1, "R1");
    rd('h002, 1, "R1");
    // R4: mask clear / set
    wr('h011, 32'h0000_02A8, "R4");   // unmask 3,5,7,9
    rd('h014, 0, "R4");
    wr('h010, 32'h0000_0080, "R4");   // re-mask 7
    rd('h014, 0, "R4");
    wr('h011, 32'h0000_0080, "R4");
    // R6/R7: single source, auto-mask
    hw_irq[5] = 1;
    idle("R9"); idle("R9");
    rd('h000, 1, "R6");
    rd('h014, 0, "R7");
    idle("R9");
    // R6: two sources, lowest wins
    hw_irq[3] = 1;
    wr('h011, 32'h0000_0020, "R4");
    rd('h000, 0, "R6");
    rd('h000, 0, "R6");
    rd('h000, 0, "R7");
    wr('h011, 32'h0000_0028, "R4");
    // R2: level, not latched
    hw_irq[3] = 0;
    idle("R2");
    rd('h000, 1, "R2");
    hw_irq[5] = 0;
    wr('h011, 32'h0000_0020, "R2");
    rd('h000, 1, "R2");
    rd('h016, 0, "R3");
    // R3: software trigger ORed with line
    wr('h012, 32'h0000_0080, "R3");
    rd('h015, 0, "R3");
    rd('h000, 0, "R3");
    wr('h011, 32'h0000_0080, "R3");
    hw_irq[7] = 1;
    wr('h013, 32'h0000_0080, "R3");
    rd('h000, 1, "R3");
    hw_irq[7] = 0;
    wr('h011, 32'h0000_0080, "R3");
    rd('h000, 1, "R3");
    // R5: routing to one CPU
    wr('h049, 32'h0000_0002, "R5");
    rd('h049, 0, "R5");
    hw_irq[9] = 1;
    idle("R5"); idle("R5");
    rd('h000, 0, "R5");
    rd('h000, 1, "R5");
    rd('h000, 1, "R5");
    // R8: IPIs outrank hardware, IPI0 before IPI1
    wr('h011, 32'h0000_0200, "R8");
    wr('h001, 32'h0000_0002, "R8");   // cpu0, IPI1
    rd('h002, 0, "R8");
    rd('h000, 0, "R8");
    rd('h000, 0, "R8");
    wr('h001, 32'h0000_0103, "R8");   // cpu1, both
    rd('h000, 1, "R8");
    rd('h000, 1, "R8");
    rd('h000, 1, "R8");
    wr('h001, 32'h0000_0501, "R8");   // target out of range
    rd('h002, 0, "R8");
    rd('h002, 1, "R8");
    // R10: views
    wr('h011, 32'h0000_0200, "R10");
    rd('h200, 0, "R10");               // explicit CPU1 view from CPU0
    rd('h000, 1, "R10");
    wr('h001, 32'h0000_0001, "R10");
    rd('h102, 1, "R10");               // CPU0 view from CPU1
    rd('h300, 0, "R10");               // out-of-range view: zero, no ack
    wr('h311, 32'hFFFF_FFFF, "R10");   // ignored
    rd('h014, 0, "R10");
    rd('h100, 1, "R10");
    rd('h000, 0, "R10");
    hw_irq = '0;
    idle("R11"); idle("R11");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule